// File: doc/BRIEF.md
# Pointer Relocation Fixup Unit

This block keeps a small register file consistent when a fixed-size memory object moves. Each object is 256 bits long and sits on a 32-byte boundary, so its base address always ends in five zero bits. A register holds a 64-bit value plus one tag bit that marks the value as a pointer. A pointer refers to an object when bits [63:5] match the object's base. Bits [4:0] pick a byte inside the object.

A move command supplies the old and the new base. The command is taken only while the unit is idle. The unit then visits the sixteen registers in ascending order, one per clock. Each tagged register whose upper bits match the old base gets the upper bits of the new base and keeps its own byte offset. Untagged registers are never touched. While the scan runs, the unit reports busy and refuses writes from outside, so no pointer can be written behind the scan. At the end it raises a one-cycle done pulse and shows how many registers it changed. A command with a base whose low five bits are not zero is rejected with a one-cycle error pulse.

Top module: `ptr_fixup_unit`

## Requirements
- R1: After reset: ready_o=1, busy_o=0, done_o=0, err_o=0 and fix_count_o=0. Every entry reads back as value 0 with tag 0.
- R2: A start_i sampled at a clock edge, with ready_o=1 and both bases aligned, is accepted. busy_o is high from that edge on. done_o is high for exactly one cycle, in the 16th cycle after the accepting edge. busy_o is low in that same cycle and ready_o is high.
- R3: An entry matches when its tag is 1 and its bits [63:5] equal bits [63:5] of the old base. Bits [4:0] of the entry play no part in the match.
- R4: A matching entry becomes {new_base[63:5], original bits [4:0]}. Its tag stays 1. An entry that does not match keeps its value.
- R5: An entry with tag 0 is never changed by a move, even when its value equals the old base in bits [63:5].
- R6: When done_o is high, fix_count_o equals the number of entries rewritten by that move. fix_count_o holds that value until the next move is accepted.
- R7: A start_i with ready_o=1 and old_base_i[4:0]!=0 or new_base_i[4:0]!=0 is rejected. err_o is high for the one following cycle. No scan starts, and neither the entries nor fix_count_o change.
- R8: A write (wr_en_i=1) at an edge where busy_o is low stores wr_data_i and wr_tag_i into entry wr_idx_i. This includes the edge that accepts a move, and the scan then sees the written value. A write while busy_o is high is ignored.
- R9: A start_i while busy_o is high is ignored. The running scan keeps its bases and its done timing.
- R10: rd_data_o and rd_tag_o show, combinationally, the value and tag of entry rd_idx_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Move command request |
| old_base_i | input | 64 | Base address the object is leaving |
| new_base_i | input | 64 | Base address the object moves to |
| ready_o | output | 1 | Unit idle, command can be taken |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse at the end of a scan |
| err_o | output | 1 | One-cycle pulse after a rejected misaligned command |
| fix_count_o | output | 5 | Registers rewritten by the last move |
| wr_en_i | input | 1 | External register write enable |
| wr_idx_i | input | 4 | External write entry index |
| wr_data_i | input | 64 | External write value |
| wr_tag_i | input | 1 | External write pointer tag |
| rd_idx_i | input | 4 | Read entry index |
| rd_data_o | output | 64 | Value of the read entry |
| rd_tag_o | output | 1 | Tag of the read entry |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is an external write and the acceptance of a move. The bench writes a tagged pointer into entry 0 in the cycle that start_i is accepted. It then expects entry 0 to come back relocated with its own offset kept, because the write has to land before the scan reaches entry 0. The second pair is a scan step and a blocked write. While busy_o is high, the bench drives writes and a second start_i. It judges the result by the final register contents, by the count and by an unchanged done latency of 16 cycles.

// File: rtl/ptr_fixup_pkg.sv
package ptr_fixup_pkg;
  localparam int unsigned PTR_W  = 64;
  localparam int unsigned OFS_W  = 5;
  localparam int unsigned N_REGS = 16;

  typedef enum logic {
    SC_IDLE = 1'b0,
    SC_SCAN = 1'b1
  } scan_state_e;
endpackage

// File: rtl/fixup_match.sv
module fixup_match #(
  parameter int unsigned PTR_W = 64,
  parameter int unsigned OFS_W = 5
) (
  input  logic [PTR_W-1:0] cur_data_i,
  input  logic             cur_tag_i,
  input  logic [PTR_W-1:0] old_base_i,
  input  logic [PTR_W-1:0] new_base_i,
  output logic             hit_o,
  output logic [PTR_W-1:0] fix_data_o
);
  // Object identity lives above the offset field; offsets survive relocation.
  always_comb begin
    hit_o      = cur_tag_i && (cur_data_i[PTR_W-1:OFS_W] == old_base_i[PTR_W-1:OFS_W]);
    fix_data_o = {new_base_i[PTR_W-1:OFS_W], cur_data_i[OFS_W-1:0]};
  end
endmodule

// File: rtl/fixup_ctrl.sv
module fixup_ctrl
  import ptr_fixup_pkg::*;
#(
  parameter int unsigned PTR_W  = 64,
  parameter int unsigned OFS_W  = 5,
  parameter int unsigned N_REGS = 16,
  localparam int unsigned IDX_W = $clog2(N_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [PTR_W-1:0] old_base_i,
  input  logic [PTR_W-1:0] new_base_i,
  output logic             busy_o,
  output logic             accept_o,
  output logic             done_o,
  output logic             err_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [PTR_W-1:0] old_base_o,
  output logic [PTR_W-1:0] new_base_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_REGS - 1);

  scan_state_e      state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [PTR_W-1:0] old_q, new_q;
  logic             done_q, done_d, err_q, err_d;
  logic             aligned, accept, base_en;

  always_comb begin
    aligned = (old_base_i[OFS_W-1:0] == '0) && (new_base_i[OFS_W-1:0] == '0);
    accept  = (state_q == SC_IDLE) && start_i && aligned;
    base_en = accept;
    state_d = state_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    err_d   = (state_q == SC_IDLE) && start_i && !aligned;
    if (state_q == SC_IDLE) begin
      if (accept) begin
        state_d = SC_SCAN;
        idx_d   = '0;
      end
    end else begin
      idx_d = idx_q + IDX_W'(1);
      if (idx_q == LAST_IDX) begin
        state_d = SC_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SC_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_q <= '0;
      new_q <= '0;
    end else if (base_en) begin
      old_q <= old_base_i;
      new_q <= new_base_i;
    end
  end

  assign busy_o     = (state_q == SC_SCAN);
  assign accept_o   = accept;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign idx_o      = idx_q;
  assign old_base_o = old_q;
  assign new_base_o = new_q;

  assert_scan_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
  assert_done_ends_scan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
  assert_idx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (idx_o == $past(idx_o) + IDX_W'(1)));
  assert_reject_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($past(start_i) && !busy_o));
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(old_base_o) && $stable(new_base_o)));
endmodule

// File: rtl/ptr_regfile.sv
module ptr_regfile #(
  parameter int unsigned PTR_W  = 64,
  parameter int unsigned N_REGS = 16,
  localparam int unsigned IDX_W = $clog2(N_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [PTR_W-1:0] wr_data_i,
  input  logic             wr_tag_i,
  input  logic             fx_we_i,
  input  logic [IDX_W-1:0] fx_idx_i,
  input  logic [PTR_W-1:0] fx_data_i,
  input  logic [IDX_W-1:0] sc_idx_i,
  output logic [PTR_W-1:0] sc_data_o,
  output logic             sc_tag_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [PTR_W-1:0] rd_data_o,
  output logic             rd_tag_o
);
  logic [N_REGS-1:0][PTR_W-1:0] mem_q;
  logic [N_REGS-1:0]            tag_q;
  logic                         ext_we;

  assign ext_we = wr_en_i && !blk_i;

  for (genvar g = 0; g < N_REGS; g++) begin : g_entry
    logic             ext_hit, fx_hit, ent_en;
    logic [PTR_W-1:0] data_d;
    logic             tag_d;

    always_comb begin
      ext_hit = ext_we && (wr_idx_i == IDX_W'(g));
      fx_hit  = fx_we_i && (fx_idx_i == IDX_W'(g));
      ent_en  = ext_hit || fx_hit;
      data_d  = fx_hit ? fx_data_i : wr_data_i;
      tag_d   = fx_hit ? 1'b1 : wr_tag_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
        tag_q[g] <= 1'b0;
      end else if (ent_en) begin
        mem_q[g] <= data_d;
        tag_q[g] <= tag_d;
      end
    end

    assert_untagged_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tag_q[g] && !(wr_en_i && !blk_i && (wr_idx_i == IDX_W'(g))))
        |=> $stable(mem_q[g]));
  end

  assign sc_data_o = mem_q[sc_idx_i];
  assign sc_tag_o  = tag_q[sc_idx_i];
  assign rd_data_o = mem_q[rd_idx_i];
  assign rd_tag_o  = tag_q[rd_idx_i];

  assert_blocked_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && blk_i && !fx_we_i) |=> ($stable(mem_q) && $stable(tag_q)));
endmodule

// File: rtl/ptr_fixup_unit.sv
module ptr_fixup_unit
  import ptr_fixup_pkg::*;
#(
  parameter int unsigned PW = ptr_fixup_pkg::PTR_W,
  parameter int unsigned OW = ptr_fixup_pkg::OFS_W,
  parameter int unsigned NR = ptr_fixup_pkg::N_REGS,
  localparam int unsigned IW = $clog2(NR),
  localparam int unsigned CW = $clog2(NR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [PW-1:0] old_base_i,
  input  logic [PW-1:0] new_base_i,
  output logic          ready_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [CW-1:0] fix_count_o,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [PW-1:0] wr_data_i,
  input  logic          wr_tag_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [PW-1:0] rd_data_o,
  output logic          rd_tag_o
);
  logic          rst_m, rst_s;
  logic          busy, accept, hit, fx_we, sc_tag, cnt_en;
  logic [IW-1:0] sc_idx;
  logic [PW-1:0] sc_data, fix_data, old_b, new_b;
  logic [CW-1:0] cnt_q, cnt_d;

  // Reset asserts at once and leaves two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  fixup_ctrl #(.PTR_W(PW), .OFS_W(OW), .N_REGS(NR)) u_ctrl (
    .clk(clk), .rst_n(rst_s), .start_i(start_i),
    .old_base_i(old_base_i), .new_base_i(new_base_i),
    .busy_o(busy), .accept_o(accept), .done_o(done_o), .err_o(err_o),
    .idx_o(sc_idx), .old_base_o(old_b), .new_base_o(new_b)
  );

  ptr_regfile #(.PTR_W(PW), .N_REGS(NR)) u_rf (
    .clk(clk), .rst_n(rst_s), .blk_i(busy),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i), .wr_tag_i(wr_tag_i),
    .fx_we_i(fx_we), .fx_idx_i(sc_idx), .fx_data_i(fix_data),
    .sc_idx_i(sc_idx), .sc_data_o(sc_data), .sc_tag_o(sc_tag),
    .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o), .rd_tag_o(rd_tag_o)
  );

  fixup_match #(.PTR_W(PW), .OFS_W(OW)) u_match (
    .cur_data_i(sc_data), .cur_tag_i(sc_tag),
    .old_base_i(old_b), .new_base_i(new_b),
    .hit_o(hit), .fix_data_o(fix_data)
  );

  always_comb begin
    fx_we  = busy && hit;
    cnt_en = accept || fx_we;
    cnt_d  = accept ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready_o     = !busy;
  assign busy_o      = busy;
  assign fix_count_o = cnt_q;

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_s)
    cnt_q <= CW'(NR));
  assert_count_held_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (!busy && !accept) |=> $stable(cnt_q));
endmodule

// File: tb/ptr_fixup_unit_test.sv
module ptr_fixup_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] old_base_i = '0, new_base_i = '0;
  logic        ready_o, busy_o, done_o, err_o;
  logic [4:0]  fix_count_o;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_idx_i = '0;
  logic [63:0] wr_data_i = '0;
  logic        wr_tag_i = 1'b0;
  logic [3:0]  rd_idx_i = '0;
  logic [63:0] rd_data_o;
  logic        rd_tag_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ptr_fixup_unit uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .old_base_i(old_base_i), .new_base_i(new_base_i),
    .ready_o(ready_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .fix_count_o(fix_count_o),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i), .wr_tag_i(wr_tag_i),
    .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o), .rd_tag_o(rd_tag_o)
  );

  // {old base, new base, tag mask, match mask}
  localparam logic [159:0] VEC [0:3] = '{
    {64'h0000_1000_0000_0040, 64'h0000_2000_0000_0A00, 16'hFFFF, 16'h0F0F},
    {64'hFFFF_FFFF_FFFF_FFE0, 64'h0000_0000_0000_0000, 16'hAAAA, 16'hFFFF},
    {64'h8000_0000_0000_0000, 64'h8000_0000_0000_0020, 16'h0000, 16'hFFFF},
    {64'h0123_4567_89AB_CDE0, 64'h0123_4567_89AB_CDE0, 16'h8001, 16'h8001}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [63:0] d, input logic t);
    wr_en_i = 1'b1; wr_idx_i = 4'(idx); wr_data_i = d; wr_tag_i = t;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [63:0] d, output logic t);
    rd_idx_i = 4'(idx);
    #1;
    d = rd_data_o; t = rd_tag_o;
  endtask

  function automatic logic [63:0] off_val(input logic [63:0] base, input int i);
    return {base[63:5], 5'(i * 7 + 3)};
  endfunction

  function automatic logic [63:0] miss_val(input logic [63:0] base, input int i);
    return base ^ (64'(i + 1) << 8);
  endfunction

  // start_i is held across one edge; returns cycles from the accepting edge to done.
  task automatic run_move(input logic [63:0] ob, input logic [63:0] nb, output int lat);
    start_i = 1'b1; old_base_i = ob; new_base_i = nb;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1 && ready_o === 1'b0, "R2 busy after accept", 64'(busy_o), 64'd1);
    lat = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (done_o === 1'b1) begin lat = k; break; end
    end
  endtask

  task automatic run_all();
    logic [63:0] d, ob, nb, exp;
    logic        t;
    logic [15:0] tm, mm;
    int          lat, ecount;

    // Reset state (R1)
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ready_o === 1'b1 && busy_o === 1'b0, "R1 ready/busy", {62'd0, ready_o, busy_o}, 64'd2);
    chk(done_o === 1'b0 && err_o === 1'b0, "R1 done/err", {62'd0, done_o, err_o}, 64'd0);
    chk(fix_count_o === 5'd0, "R1 count", 64'(fix_count_o), 64'd0);
    for (int i = 0; i < 16; i++) begin
      rd(i, d, t);
      chk(d === 64'd0 && t === 1'b0, "R1 entry clear", d, 64'd0);
    end

    // Table walk (R2 R3 R4 R5 R6 R10)
    for (int v = 0; v < 4; v++) begin
      {ob, nb, tm, mm} = VEC[v];
      for (int i = 0; i < 16; i++)
        wr(i, mm[i] ? off_val(ob, i) : miss_val(ob, i), tm[i]);
      run_move(ob, nb, lat);
      chk(lat == 16, "R2 done latency", 64'(lat), 64'd16);
      chk(busy_o === 1'b0 && ready_o === 1'b1, "R2 idle at done", 64'(busy_o), 64'd0);
      ecount = 0;
      for (int i = 0; i < 16; i++) begin
        if (tm[i] && mm[i]) begin
          exp = {nb[63:5], 5'(i * 7 + 3)};
          ecount++;
        end else begin
          exp = mm[i] ? off_val(ob, i) : miss_val(ob, i);
        end
        rd(i, d, t);
        chk(d === exp, tm[i] ? "R3 R4 tagged entry" : "R5 untagged entry", d, exp);
        chk(t === tm[i], "R4 R10 tag kept", 64'(t), 64'(tm[i]));
      end
      chk(fix_count_o === 5'(ecount), "R6 rewrite count", 64'(fix_count_o), 64'(ecount));
      @(negedge clk);
      chk(done_o === 1'b0, "R2 done one cycle", 64'(done_o), 64'd0);
      chk(fix_count_o === 5'(ecount), "R6 count held", 64'(fix_count_o), 64'(ecount));
    end
    // fix_count_o is now 2 from the last row.

    // Misaligned command rejected (R7)
    rd(3, d, t);
    exp = d;
    start_i = 1'b1; old_base_i = 64'h0000_4000_0000_0004; new_base_i = 64'h0000_5000_0000_0000;
    @(negedge clk);
    start_i = 1'b0;
    chk(err_o === 1'b1, "R7 err on misaligned old", 64'(err_o), 64'd1);
    chk(busy_o === 1'b0, "R7 no scan", 64'(busy_o), 64'd0);
    @(negedge clk);
    chk(err_o === 1'b0 && busy_o === 1'b0, "R7 err one cycle", 64'(err_o), 64'd0);
    start_i = 1'b1; old_base_i = 64'h0123_4567_89AB_CDE0; new_base_i = 64'h0000_5000_0000_0011;
    @(negedge clk);
    start_i = 1'b0;
    chk(err_o === 1'b1, "R7 err on misaligned new", 64'(err_o), 64'd1);
    repeat (20) @(negedge clk);
    chk(busy_o === 1'b0 && done_o === 1'b0, "R7 still idle", 64'(busy_o), 64'd0);
    chk(fix_count_o === 5'd2, "R7 count unchanged", 64'(fix_count_o), 64'd2);
    rd(3, d, t);
    chk(d === exp, "R7 entry unchanged", d, exp);

    // Same-cycle write with accept, blocked writes and restart during scan (R8 R9)
    ob = 64'h0000_0000_CAFE_0000;
    nb = 64'h0000_0000_BEEF_0100;
    wr(0, 64'h1, 1'b0);
    for (int i = 1; i < 16; i++) wr(i, off_val(ob, i), 1'b1);
    start_i = 1'b1; old_base_i = ob; new_base_i = nb;
    wr_en_i = 1'b1; wr_idx_i = 4'd0; wr_data_i = {ob[63:5], 5'h11}; wr_tag_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wr_idx_i = 4'd5; wr_data_i = {ob[63:5], 5'h1F}; wr_tag_i = 1'b0;
    @(negedge clk);
    wr_idx_i = 4'd15; wr_data_i = 64'h0;
    @(negedge clk);
    wr_en_i = 1'b0;
    start_i = 1'b1; old_base_i = 64'h0000_0000_BEEF_0100; new_base_i = 64'h0000_0000_0000_0000;
    @(negedge clk);
    start_i = 1'b0;
    lat = 3;
    for (int k = 4; k <= 40; k++) begin
      if (done_o === 1'b1) break;
      @(negedge clk);
      lat = k;
    end
    chk(lat == 16, "R9 done timing kept", 64'(lat), 64'd16);
    chk(fix_count_o === 5'd16, "R8 R9 count", 64'(fix_count_o), 64'd16);
    rd(0, d, t);
    chk(d === {nb[63:5], 5'h11} && t === 1'b1, "R8 same-cycle write scanned", d, {nb[63:5], 5'h11});
    rd(5, d, t);
    exp = {nb[63:5], 5'(5 * 7 + 3)};
    chk(d === exp && t === 1'b1, "R8 blocked write ignored", d, exp);
    rd(15, d, t);
    exp = {nb[63:5], 5'(15 * 7 + 3)};
    chk(d === exp, "R8 R9 last entry", d, exp);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule